// File: doc/BRIEF.md
# Register Add-Logical Execution Unit

This unit executes one two-byte register-to-register instruction: an unsigned add of 32-bit words held in a bank of sixteen 64-bit general registers. A 16-bit instruction word is offered on a valid/ready handshake. If its opcode field matches the add-logical code, the unit reads the two named registers. It adds their low words as unsigned numbers and writes the low 32 bits of the sum back into the target register. A 2-bit condition code records the carry-out and whether the result is nonzero. The upper half of the target register is left untouched.

Any other opcode is rejected. The unit pulses an illegal-opcode flag and changes no register and no condition code. The condition code lets software build wider additions: add the low words first, then, if the carry bit is set, add one to the next higher word.

A preload write port sets a full 64-bit register so that a test environment can arrange operands. A debug read port returns any register, and the condition code is always visible. While a preload is driven the unit does not accept instructions.

Top module: `addl_exec`

## Requirements
- R1: A synchronous active-low reset clears all sixteen registers and the condition code to zero, and leaves `done` and `illegal` low.
- R2: Instruction bits 15:8 carry the opcode, bits 7:4 name the target register and bits 3:0 name the source register. An instruction with opcode 8'h1E that is accepted at a clock edge (valid and ready both high) raises `done` for exactly the following cycle. `done` is low in any cycle that does not follow an acceptance.
- R3: When such an instruction completes, bits 31:0 of the target register equal (target[31:0] + source[31:0]) mod 2^32, using the values from before the instruction. The new value is readable on the debug port in the same cycle as `done`.
- R4: Bits 63:32 of the target register keep their previous value.
- R5: Condition code bit 0 is 1 when the 32-bit result is nonzero and 0 when it is zero. The condition code changes only in a cycle where `done` is high.
- R6: Condition code bit 1 equals the carry-out, bit 32 of the 33-bit sum. So the code is 0 for zero with no carry, 1 for nonzero with no carry, 2 for zero with carry and 3 for nonzero with carry.
- R7: When source and target name the same register, both operands are the original value, so the low word becomes twice the original low word modulo 2^32.
- R8: An accepted instruction whose opcode is not 8'h1E raises `illegal` for exactly the following cycle, does not raise `done`, and changes no register and not the condition code.
- R9: With `load_en` high, the full 64-bit `load_data` is written to register `load_idx` at the clock edge, and `insn_ready` is low for that cycle.
- R10: A 64-bit unsigned add built by adding the low words, then adding the high words, then adding one to the high word when the condition code after the low add is 2 or 3 gives the exact 64-bit sum.
- R11: The source register is unchanged when it differs from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 16 | Instruction: opcode 15:8, target 7:4, source 3:0 |
| insn_ready | output | 1 | Unit can accept an instruction (low during preload) |
| load_en | input | 1 | Preload write strobe |
| load_idx | input | 4 | Register written by preload |
| load_data | input | 64 | Full-width preload value |
| dbg_idx | input | 4 | Register selected for debug read |
| dbg_data | output | 64 | Contents of the selected register (combinational) |
| cond_code | output | 2 | Condition code: bit 1 carry, bit 0 nonzero |
| done | output | 1 | One-cycle pulse after an add is accepted |
| illegal | output | 1 | One-cycle pulse after an unknown opcode is accepted |

## Verification
An instruction is accepted at a rising edge. That edge also writes the target register and the condition code and raises `done` or `illegal`. All of these results therefore belong to the single cycle that follows the acceptance. The bench drives each instruction just after a falling edge and holds it across one rising edge only. It samples the pulse flags, the condition code and the registers (through the combinational debug port) at the next falling edge. It then checks at the falling edge one cycle later that the pulse has cleared. A preload is checked the same way: `insn_ready` is sampled while the strobe is up, and the register contents after the edge that wrote them.

// File: rtl/addl_pkg.sv
// Package addl_pkg
// Shared sizes and codes for the register add-logical execution unit.
// Assumes the instruction word holds the opcode in its top byte and two
// register indices below it, target index above source index.
package addl_pkg;
    localparam int unsigned GPR_COUNT = 16;
    localparam int unsigned GPR_W     = 64;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned INSN_W    = 16;
    localparam int unsigned OPC_W     = 8;
    localparam int unsigned IDX_W     = $clog2(GPR_COUNT);
    localparam logic [OPC_W-1:0] OPC_ADDL = 8'h1E;

    // Decoded view of one instruction word
    typedef struct packed {
        logic             legal;
        logic [IDX_W-1:0] tgt;
        logic [IDX_W-1:0] src;
    } insn_fields_t;
endpackage

// File: rtl/addl_decode.sv
// Module addl_decode
// Splits an instruction word into its opcode test and two register indices.
// Assumes INSN_W >= OPC_W + 2*IDX_W; indices sit in the low bits, target
// index above source index, opcode in the top OPC_W bits.
module addl_decode
    import addl_pkg::*;
#(
    parameter int unsigned P_INSN_W = INSN_W,
    parameter int unsigned P_OPC_W  = OPC_W,
    parameter int unsigned P_IDX_W  = IDX_W,
    parameter logic [P_OPC_W-1:0] P_OPCODE = OPC_ADDL
) (
    input  logic [P_INSN_W-1:0] insn_word,
    output logic                legal,
    output logic [P_IDX_W-1:0]  tgt_idx,
    output logic [P_IDX_W-1:0]  src_idx
);
    localparam int unsigned OPC_LSB = P_INSN_W - P_OPC_W;

    // Field extraction and opcode match
    always_comb begin
        legal   = (insn_word[P_INSN_W-1:OPC_LSB] == P_OPCODE);
        tgt_idx = insn_word[2*P_IDX_W-1:P_IDX_W];
        src_idx = insn_word[P_IDX_W-1:0];
    end
endmodule

// File: rtl/addl_word_add.sv
// Module addl_word_add
// Unsigned add of two words producing the wrapped sum and a 2-bit
// condition code {carry_out, result_nonzero}.
// Assumes operands are already the low words of the registers.
module addl_word_add #(
    parameter int unsigned P_WORD_W = 32
) (
    input  logic [P_WORD_W-1:0] op_a,
    input  logic [P_WORD_W-1:0] op_b,
    output logic [P_WORD_W-1:0] sum,
    output logic [1:0]          cc
);
    logic [P_WORD_W:0] wide_sum;

    // Widened add, then condition code from carry and zero test
    always_comb begin
        wide_sum = {1'b0, op_a} + {1'b0, op_b};
        sum      = wide_sum[P_WORD_W-1:0];
        cc       = {wide_sum[P_WORD_W], |wide_sum[P_WORD_W-1:0]};
    end
endmodule

// File: rtl/addl_gpr_file.sv
// Module addl_gpr_file
// General register bank with one full-width preload write port, one
// low-word write port, two low-word read ports and one full-width debug
// read port. Reads are combinational; writes happen at the rising edge.
// Assumes the two write ports never target a register in the same cycle;
// if they do, the preload wins.
module addl_gpr_file #(
    parameter int unsigned P_COUNT  = 16,
    parameter int unsigned P_REG_W  = 64,
    parameter int unsigned P_WORD_W = 32,
    parameter int unsigned P_IDX_W  = $clog2(P_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pre_we,
    input  logic [P_IDX_W-1:0]  pre_idx,
    input  logic [P_REG_W-1:0]  pre_data,
    input  logic                low_we,
    input  logic [P_IDX_W-1:0]  low_idx,
    input  logic [P_WORD_W-1:0] low_data,
    input  logic [P_IDX_W-1:0]  rd_a_idx,
    output logic [P_WORD_W-1:0] rd_a_data,
    input  logic [P_IDX_W-1:0]  rd_b_idx,
    output logic [P_WORD_W-1:0] rd_b_data,
    input  logic [P_IDX_W-1:0]  dbg_idx,
    output logic [P_REG_W-1:0]  dbg_data
);
    logic [P_REG_W-1:0] gpr_view [P_COUNT];

    for (genvar g = 0; g < P_COUNT; g++) begin : g_entry
        logic [P_REG_W-1:0] entry_q;

        // Per-register storage: reset, full preload, or low-word update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (pre_we && (pre_idx == P_IDX_W'(g))) begin
                entry_q <= pre_data;
            end else if (low_we && (low_idx == P_IDX_W'(g))) begin
                entry_q[P_WORD_W-1:0] <= low_data;
            end
        end

        assign gpr_view[g] = entry_q;
    end

    // Combinational read multiplexers
    always_comb begin
        rd_a_data = gpr_view[rd_a_idx][P_WORD_W-1:0];
        rd_b_data = gpr_view[rd_b_idx][P_WORD_W-1:0];
        dbg_data  = gpr_view[dbg_idx];
    end
endmodule

// File: rtl/addl_exec.sv
// Module addl_exec
// Top of the register add-logical execution unit. An instruction accepted
// at a rising edge is decoded, its registers read and summed in the same
// cycle; that edge writes the target low word and the condition code and
// arms a one-cycle done (or illegal) pulse for the following cycle.
// Assumes the preload port is test set-up only; while it is driven the
// unit refuses instructions so the two writes never meet.
module addl_exec
    import addl_pkg::*;
#(
    parameter int unsigned P_COUNT  = GPR_COUNT,
    parameter int unsigned P_REG_W  = GPR_W,
    parameter int unsigned P_WORD_W = WORD_W,
    parameter int unsigned P_INSN_W = INSN_W,
    parameter int unsigned P_OPC_W  = OPC_W,
    parameter logic [P_OPC_W-1:0] P_OPCODE = OPC_ADDL,
    localparam int unsigned L_IDX_W = $clog2(P_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [P_INSN_W-1:0] insn_word,
    output logic                insn_ready,
    input  logic                load_en,
    input  logic [L_IDX_W-1:0]  load_idx,
    input  logic [P_REG_W-1:0]  load_data,
    input  logic [L_IDX_W-1:0]  dbg_idx,
    output logic [P_REG_W-1:0]  dbg_data,
    output logic [1:0]          cond_code,
    output logic                done,
    output logic                illegal
);
    logic                accept;
    logic                op_legal;
    logic [L_IDX_W-1:0]  tgt_idx;
    logic [L_IDX_W-1:0]  src_idx;
    logic [P_WORD_W-1:0] tgt_word;
    logic [P_WORD_W-1:0] src_word;
    logic [P_WORD_W-1:0] sum_word;
    logic [1:0]          sum_cc;
    logic                exec_we;
    logic [1:0]          cc_q;
    logic                done_q;
    logic                illegal_q;

    // Handshake: preload has priority over instruction acceptance
    always_comb begin
        insn_ready = !load_en;
        accept     = insn_valid && insn_ready;
        exec_we    = accept && op_legal;
    end

    addl_decode #(
        .P_INSN_W (P_INSN_W),
        .P_OPC_W  (P_OPC_W),
        .P_IDX_W  (L_IDX_W),
        .P_OPCODE (P_OPCODE)
    ) i_decode (
        .insn_word (insn_word),
        .legal     (op_legal),
        .tgt_idx   (tgt_idx),
        .src_idx   (src_idx)
    );

    addl_gpr_file #(
        .P_COUNT  (P_COUNT),
        .P_REG_W  (P_REG_W),
        .P_WORD_W (P_WORD_W),
        .P_IDX_W  (L_IDX_W)
    ) i_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (load_en),
        .pre_idx   (load_idx),
        .pre_data  (load_data),
        .low_we    (exec_we),
        .low_idx   (tgt_idx),
        .low_data  (sum_word),
        .rd_a_idx  (tgt_idx),
        .rd_a_data (tgt_word),
        .rd_b_idx  (src_idx),
        .rd_b_data (src_word),
        .dbg_idx   (dbg_idx),
        .dbg_data  (dbg_data)
    );

    addl_word_add #(
        .P_WORD_W (P_WORD_W)
    ) i_add (
        .op_a (tgt_word),
        .op_b (src_word),
        .sum  (sum_word),
        .cc   (sum_cc)
    );

    // Condition code register, updated together with the register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
        end else if (exec_we) begin
            cc_q <= sum_cc;
        end
    end

    // Completion and rejection pulses for the cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= exec_we;
            illegal_q <= accept && !op_legal;
        end
    end

    assign cond_code = cc_q;
    assign done      = done_q;
    assign illegal   = illegal_q;
endmodule

// File: rtl/addl_exec_chk.sv
// Module addl_exec_chk
// Port-level protocol checks for addl_exec, attached by bind.
// Assumes the same opcode parameters as the unit it watches.
module addl_exec_chk #(
    parameter int unsigned P_INSN_W = 16,
    parameter int unsigned P_OPC_W  = 8,
    parameter logic [P_OPC_W-1:0] P_OPCODE = 8'h1E
) (
    input logic                clk,
    input logic                rst_n,
    input logic                insn_valid,
    input logic                insn_ready,
    input logic [P_INSN_W-1:0] insn_word,
    input logic [1:0]          cond_code,
    input logic                done,
    input logic                illegal
);
    logic acc_c;
    logic hit_c;
    assign acc_c = insn_valid && insn_ready;
    assign hit_c = insn_word[P_INSN_W-1 -: P_OPC_W] == P_OPCODE;

    AST_DONE_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_c && hit_c) |=> (done && !illegal)); // R2
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_c |=> (!done && !illegal)); // R2
    AST_ILLEGAL_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_c && !hit_c) |=> (illegal && !done && $stable(cond_code))); // R8
    AST_CC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cond_code)); // R5
    AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal})); // R8
endmodule

bind addl_exec addl_exec_chk #(
    .P_INSN_W (P_INSN_W),
    .P_OPC_W  (P_OPC_W),
    .P_OPCODE (P_OPCODE)
) i_addl_exec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_ready (insn_ready),
    .insn_word  (insn_word),
    .cond_code  (cond_code),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/test_addl_exec.sv
`timescale 1ns/100ps
module test_addl_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_word = '0;
    logic        insn_ready;
    logic        load_en = 1'b0;
    logic [3:0]  load_idx = '0;
    logic [63:0] load_data = '0;
    logic [3:0]  dbg_idx = '0;
    logic [63:0] dbg_data;
    logic [1:0]  cond_code;
    logic        done;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    addl_exec i_addl_exec (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .insn_ready(insn_ready), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .cond_code(cond_code), .done(done), .illegal(illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cc(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return {s[32], s[31:0] != 32'd0};
    endfunction

    function automatic logic [15:0] enc(input logic [7:0] opc, input logic [3:0] t, input logic [3:0] s);
        return {opc, t, s};
    endfunction

    // Read a register through the debug port; call just after a falling edge
    task automatic peek(input logic [3:0] idx, output logic [63:0] v);
        dbg_idx = idx;
        #0.1;
        v = dbg_data;
    endtask

    task automatic preload(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        load_en = 1'b1; load_idx = idx; load_data = val;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Offer one instruction for one edge; return at the falling edge after it
    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        insn_valid = 1'b1; insn_word = w;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        @(negedge clk);
        check("R1 cond_code after reset", 64'(cond_code), 64'd0);
        check("R1 done after reset", 64'(done), 64'd0);
        check("R1 illegal after reset", 64'(illegal), 64'd0);
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v);
            check("R1 register cleared", v, 64'd0);
        end
    endtask

    // Generic add scenario: preload, execute, check result, high word, cc, source
    task automatic t_add(input string tag, input logic [3:0] t, input logic [3:0] s,
                         input logic [63:0] tv, input logic [63:0] sv);
        logic [63:0] v;
        logic [31:0] lo;
        preload(t, tv);
        if (s != t) preload(s, sv);
        issue(enc(8'h1E, t, s));
        lo = (s == t) ? tv[31:0] + tv[31:0] : tv[31:0] + sv[31:0];
        check({"R2 done pulse ", tag}, 64'(done), 64'd1);
        check({"R6 R5 cond_code ", tag}, 64'(cond_code),
              64'((s == t) ? exp_cc(tv[31:0], tv[31:0]) : exp_cc(tv[31:0], sv[31:0])));
        peek(t, v);
        check({"R3 low word ", tag}, 64'(v[31:0]), 64'(lo));
        check({"R4 high word kept ", tag}, 64'(v[63:32]), 64'(tv[63:32]));
        if (s != t) begin
            peek(s, v);
            check({"R11 source kept ", tag}, v, sv);
        end
        @(negedge clk);
        check({"R2 done one cycle ", tag}, 64'(done), 64'd0);
    endtask

    task automatic t_illegal;
        logic [63:0] v;
        logic [1:0] cc_before;
        preload(4'd7, 64'h1111_2222_3333_4444);
        preload(4'd9, 64'h0000_0000_FFFF_FFFF);
        issue(enc(8'h1E, 4'd7, 4'd9));       // leaves a nonzero cc (3)
        cc_before = cond_code;
        issue(enc(8'h1A, 4'd7, 4'd9));
        check("R8 illegal pulse", 64'(illegal), 64'd1);
        check("R8 no done", 64'(done), 64'd0);
        check("R8 cc unchanged", 64'(cond_code), 64'(cc_before));
        peek(4'd7, v);
        check("R8 target unchanged", v, 64'h1111_2222_3333_4443);
        @(negedge clk);
        check("R8 illegal one cycle", 64'(illegal), 64'd0);
    endtask

    task automatic t_preload;
        logic [63:0] v;
        @(negedge clk);
        load_en = 1'b1; load_idx = 4'd14; load_data = 64'hDEAD_BEEF_0123_4567;
        #0.1;
        check("R9 ready low during preload", 64'(insn_ready), 64'd0);
        @(negedge clk);
        load_en = 1'b0;
        #0.1;
        check("R9 ready high after preload", 64'(insn_ready), 64'd1);
        peek(4'd14, v);
        check("R9 full-width preload", v, 64'hDEAD_BEEF_0123_4567);
    endtask

    // 64-bit add from two 32-bit adds plus a carry increment
    task automatic t_wide;
        logic [63:0] a, b, lo, hi, got;
        a = 64'h0000_0001_FFFF_FFFF;
        b = 64'h0000_0002_0000_0001;
        preload(4'd8, {32'd0, a[31:0]});
        preload(4'd9, {32'd0, b[31:0]});
        preload(4'd10, {32'd0, a[63:32]});
        preload(4'd11, {32'd0, b[63:32]});
        preload(4'd12, 64'd1);
        issue(enc(8'h1E, 4'd8, 4'd9));
        check("R10 low add cc", 64'(cond_code), 64'd2);
        if (cond_code[1]) begin
            issue(enc(8'h1E, 4'd10, 4'd11));
            issue(enc(8'h1E, 4'd10, 4'd12));
        end else begin
            issue(enc(8'h1E, 4'd10, 4'd11));
        end
        peek(4'd8, lo);
        peek(4'd10, hi);
        got = {hi[31:0], lo[31:0]};
        check("R10 64-bit sum", got, a + b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add("basic", 4'd1, 4'd2, 64'hAAAA_5555_0000_0005, 64'h1234_5678_0000_0003);
        t_add("zero", 4'd3, 4'd4, 64'hFFFF_0000_0000_0000, 64'h0000_0000_0000_0000);
        t_add("carry zero", 4'd5, 4'd0, 64'h0000_0001_FFFF_FFFF, 64'h7777_0000_0000_0001);
        t_add("carry nonzero", 4'd15, 4'd13, 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_0000_0020);
        t_add("R7 same reg", 4'd6, 4'd6, 64'h5A5A_0000_8000_0001, 64'd0);
        t_add("R7 same reg nc", 4'd2, 4'd2, 64'h0000_0009_0000_1000, 64'd0);
        t_illegal();
        t_preload();
        t_wide();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule